// File: doc/BRIEF.md
# Collision Detect Translator

This block produces the single collision-detect indication that a MAC consumes. It works in one of two modes. In attachment-unit mode an external transceiver reports a collision by toggling a collision-presence line at 10 MHz. The block receives that line already digitised but not aligned to any clock. It synchronises the line, watches it for transitions and raises collision while the toggling continues. Once the toggling stops it drops collision after a short, fixed number of cycles.

In twisted-pair mode no separate collision line exists. Collision is declared whenever the receive decoder reports carrier while transmit enable is high. A static mode input chooses the source. The block runs from the 20 MHz system clock.

The attachment-unit path is built around a small activity state machine with three states. `CD_IDLE` means no recent transition. `CD_ARMED` means at least one transition was seen but not yet enough to trust. `CD_ACTIVE` means collision is being reported. The transitions are:

- Start: `CD_IDLE` moves to `CD_ARMED` on a transition.
- Confirm: `CD_ARMED` moves to `CD_ACTIVE` on a transition that brings the count to `MIN_EDGES`.
- Discard: `CD_ARMED` moves to `CD_IDLE` when the gap counter expires.
- Release: `CD_ACTIVE` moves to `CD_IDLE` when the gap counter expires.

Every transition restarts the gap counter.

Top module: `coldet_xlate`

## Requirements
- R1: While `rst_n` is low, `col_out` is 0 in both modes, whatever `col_in`, `crs` and `tx_en` do.
- R2: With `mode_tp` = 0 (attachment-unit mode), transitions of `col_in` spaced at most `TIMEOUT_CYC` (3) cycles apart make `col_out` rise. It rises exactly 3 cycles after the second transition is driven: 2 cycles to synchronise and 1 cycle to detect the transition.
- R3: With `mode_tp` = 0, a lone transition of `col_in` followed by quiet never raises `col_out`.
- R4: With `mode_tp` = 0, transitions spaced more than `TIMEOUT_CYC` cycles apart never raise `col_out`.
- R5: With `mode_tp` = 0, `col_out` falls exactly `3 + TIMEOUT_CYC` cycles after the last transition of `col_in` is driven.
- R6: With `mode_tp` = 0, `col_out` stays high without a gap while transitions keep arriving at most `TIMEOUT_CYC` cycles apart.
- R7: With `mode_tp` = 1 (twisted-pair mode), `col_out` equals `crs AND tx_en` as sampled at the previous clock edge.
- R8: With `mode_tp` = 1, activity on `col_in` has no effect on `col_out`.
- R9: With `mode_tp` = 0, `crs` and `tx_en` have no effect on `col_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_tp | input | 1 | 1 selects twisted-pair mode, 0 selects attachment-unit mode |
| col_in | input | 1 | Digitised collision-presence line, asynchronous |
| crs | input | 1 | Receive carrier present, from the decoder |
| tx_en | input | 1 | Transmit enable from the MAC |
| col_out | output | 1 | Collision detect to the MAC |

## Verification
The checker verifies four properties on every cycle:

- the quiet output during reset;
- in twisted-pair mode, the one-cycle tracking of carrier AND transmit enable;
- the upper bound on how long collision may stay high after `col_in` goes quiet;
- that a rise of collision in attachment-unit mode follows a recent transition on `col_in`.

Some behaviour can only be shown by the bench's scenarios. These are the exact rise cycle, the rejection of a lone transition, the rejection of slow transitions, the unbroken hold during sustained activity, and the mode independence of the unused inputs. The bench sweeps the transition spacing against the transition count to cover them.

// File: rtl/coldet_pkg.sv
package coldet_pkg;

    // Activity states of the attachment-unit collision path.
    typedef enum logic [1:0] {
        CD_IDLE   = 2'd0,
        CD_ARMED  = 2'd1,
        CD_ACTIVE = 2'd2
    } cd_state_e;

endpackage

// File: rtl/coldet_sync.sv
// Multi-stage synchroniser for the asynchronous collision line.
module coldet_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= (chain_q << 1) | STAGES'(async_i);
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/coldet_edge.sv
// Flags any change of the synchronised level (both polarities).
module coldet_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic edge_o
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
        end
    end

    assign edge_o = lvl_i ^ prev_q;

endmodule

// File: rtl/coldet_activity.sv
// Activity state machine: confirms toggling, then holds until a gap timeout.
module coldet_activity
    import coldet_pkg::*;
#(
    parameter int TIMEOUT_CYC = 3,
    parameter int MIN_EDGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic active_o
);

    localparam int CNT_W  = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC + 1);
    localparam int EDGE_W = $clog2(MIN_EDGES + 1);
    localparam logic [CNT_W-1:0]  GAP_LAST  = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [EDGE_W-1:0] EDGE_NEED = EDGE_W'(MIN_EDGES - 1);
    localparam logic [EDGE_W-1:0] EDGE_SAT  = EDGE_W'(MIN_EDGES);

    cd_state_e         state_q, state_d;
    logic [CNT_W-1:0]  gap_q;
    logic [EDGE_W-1:0] edges_q;
    logic              gap_expired;
    logic              act_q;
    cd_state_e         start_target;

    assign gap_expired = (gap_q == GAP_LAST);

    // The parameter picks whether a single transition already confirms.
    generate
        if (MIN_EDGES <= 1) begin : g_direct
            assign start_target = CD_ACTIVE;
        end else begin : g_armed
            assign start_target = CD_ARMED;
        end
    endgenerate

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CD_IDLE: begin
                if (edge_i) begin
                    state_d = start_target;          // Start
                end
            end
            CD_ARMED: begin
                if (edge_i) begin
                    if (edges_q >= EDGE_NEED) begin
                        state_d = CD_ACTIVE;         // Confirm
                    end
                end else if (gap_expired) begin
                    state_d = CD_IDLE;               // Discard
                end
            end
            CD_ACTIVE: begin
                if (!edge_i && gap_expired) begin
                    state_d = CD_IDLE;               // Release
                end
            end
            default: state_d = CD_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Gap timer and transition counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q   <= '0;
            edges_q <= '0;
        end else if (state_d == CD_IDLE) begin
            gap_q   <= '0;
            edges_q <= '0;
        end else begin
            gap_q <= edge_i ? '0 : gap_q + CNT_W'(1);
            if (edge_i && (edges_q != EDGE_SAT)) begin
                edges_q <= edges_q + EDGE_W'(1);
            end
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else begin
            act_q <= (state_d == CD_ACTIVE);
        end
    end

    assign active_o = act_q;

endmodule

// File: rtl/coldet_xlate.sv
// Collision detect translator: selects the attachment-unit activity path or
// the twisted-pair carrier-during-transmit path.
module coldet_xlate #(
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 3,
    parameter int MIN_EDGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_tp,
    input  logic col_in,
    input  logic crs,
    input  logic tx_en,
    output logic col_out
);

    logic col_lvl;
    logic col_edge;
    logic aui_col;
    logic tp_q;

    coldet_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (col_in),
        .sync_o  (col_lvl)
    );

    coldet_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (col_lvl),
        .edge_o (col_edge)
    );

    coldet_activity #(
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .MIN_EDGES   (MIN_EDGES)
    ) u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_i   (col_edge),
        .active_o (aui_col)
    );

    // Twisted-pair path: carrier while transmitting.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tp_q <= 1'b0;
        end else begin
            tp_q <= crs & tx_en;
        end
    end

    always_comb begin
        col_out = mode_tp ? tp_q : aui_col;
    end

endmodule

// File: rtl/coldet_xlate_chk.sv
module coldet_xlate_chk #(
    parameter int TIMEOUT_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic mode_tp,
    input logic col_in,
    input logic crs,
    input logic tx_en,
    input logic col_out
);

    localparam int Q_W = $clog2(TIMEOUT_CYC + 8);
    localparam logic [Q_W-1:0] Q_MAX     = {Q_W{1'b1}};
    localparam logic [Q_W-1:0] Q_RELEASE = Q_W'(TIMEOUT_CYC + 2);
    localparam logic [Q_W-1:0] Q_RECENT  = Q_W'(3);

    logic           prev_col;
    logic [Q_W-1:0] quiet_q;

    // Cycles since col_in last changed (saturating).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_col <= 1'b0;
            quiet_q  <= '0;
        end else begin
            prev_col <= col_in;
            if (col_in != prev_col) begin
                quiet_q <= '0;
            end else if (quiet_q != Q_MAX) begin
                quiet_q <= quiet_q + Q_W'(1);
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (col_out == 1'b0)  // R1
                else $error("col_out high during reset");
        end
    end

    AST_TP_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_tp && $past(rst_n)) |-> (col_out == $past(crs && tx_en)));  // R7

    AST_AUI_RELEASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_tp && (quiet_q >= Q_RELEASE)) |-> !col_out);  // R5

    AST_AUI_RISE_RECENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_tp && $past(!mode_tp) && $past(rst_n) && $rose(col_out))
        |-> (quiet_q < Q_RECENT));  // R2

endmodule

bind coldet_xlate coldet_xlate_chk #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_tp (mode_tp),
    .col_in  (col_in),
    .crs     (crs),
    .tx_en   (tx_en),
    .col_out (col_out)
);

// File: tb/coldet_xlate_test.sv
`timescale 1ns/1ps
module coldet_xlate_test;

    localparam int T   = 3;   // gap timeout in cycles
    localparam int LAT = 3;   // synchroniser plus transition detection

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_tp = 1'b0;
    logic col_in = 1'b0;
    logic crs = 1'b0;
    logic tx_en = 1'b0;
    logic col_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    coldet_xlate #(
        .SYNC_STAGES (2),
        .TIMEOUT_CYC (T),
        .MIN_EDGES   (2)
    ) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_tp (mode_tp),
        .col_in  (col_in),
        .crs     (crs),
        .tx_en   (tx_en),
        .col_out (col_out)
    );

    task automatic check(input logic exp, input string tag, input string what);
        n_chk++;
        if (col_out !== exp) begin
            n_fail++;
            $display("FAIL %s %s: col_out=%0b expected %0b", tag, what, col_out, exp);
        end
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // One attachment-unit scenario: n transitions spaced g cycles apart.
    task automatic run_aui(input int g, input int n, input logic tp_noise);
        int last;
        int span;
        logic hit;
        last = (n - 1) * g;
        span = last + LAT + T + 4;
        crs   = tp_noise;
        tx_en = tp_noise;
        repeat (12) @(negedge clk);
        col_in = ~col_in;                     // transition at c = 0
        for (int c = 1; c <= span; c++) begin
            @(negedge clk);
            hit = (n >= 2) && (g <= T) && (c >= g + LAT) && (c < last + LAT + T);
            if (tp_noise) check(hit, "R9", $sformatf("g=%0d n=%0d c=%0d", g, n, c));
            else if (n < 2) check(hit, "R3", $sformatf("g=%0d c=%0d", g, c));
            else if (g > T) check(hit, "R4", $sformatf("g=%0d n=%0d c=%0d", g, n, c));
            else if (c >= last + LAT) check(hit, "R5", $sformatf("g=%0d n=%0d c=%0d", g, n, c));
            else if (n >= 3 && c > g + LAT) check(hit, "R6", $sformatf("g=%0d n=%0d c=%0d", g, n, c));
            else check(hit, "R2", $sformatf("g=%0d n=%0d c=%0d", g, n, c));
            if ((c % g == 0) && (c / g < n)) col_in = ~col_in;
        end
    endtask

    initial begin
        // R1: reset with every input busy, both modes.
        mode_tp = 1'b1;
        crs = 1'b1;
        tx_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            col_in = ~col_in;
            if (i == 4) mode_tp = 1'b0;
            check(1'b0, "R1", $sformatf("reset cycle %0d", i));
        end
        col_in = 1'b0;
        crs = 1'b0;
        tx_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2..R6, R9: sweep spacing against transition count.
        mode_tp = 1'b0;
        for (int g = 1; g <= T + 2; g++) begin
            for (int n = 1; n <= 5; n++) begin
                run_aui(g, n, 1'b0);
            end
        end
        for (int g = 1; g <= T + 1; g++) begin
            run_aui(g, 4, 1'b1);
        end
        crs = 1'b0;
        tx_en = 1'b0;

        // R7, R8: twisted-pair mode, every crs/tx_en pattern, col_in toggling.
        repeat (12) @(negedge clk);
        mode_tp = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 32; k++) begin
            crs   = k[0];
            tx_en = k[1] ^ k[3];
            col_in = ~col_in;
            @(negedge clk);
            check(crs & tx_en, (crs & tx_en) ? "R7" : "R8",
                  $sformatf("tp step %0d crs=%0b tx_en=%0b", k, crs, tx_en));
        end
        crs = 1'b0;
        tx_en = 1'b0;
        for (int k = 0; k < 6; k++) begin
            col_in = ~col_in;
            @(negedge clk);
            check(1'b0, "R8", $sformatf("tp quiet carrier step %0d", k));
        end

        // R1: reset in the middle of an attachment-unit collision.
        mode_tp = 1'b0;
        repeat (12) @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            col_in = ~col_in;
            @(negedge clk);
        end
        check(1'b1, "R2", "collision active before mid-run reset");
        rst_n = 1'b0;
        #0.5;
        check(1'b0, "R1", "immediate clear on reset");
        for (int k = 0; k < 4; k++) begin
            col_in = ~col_in;
            @(negedge clk);
            check(1'b0, "R1", $sformatf("mid-run reset cycle %0d", k));
        end
        rst_n = 1'b1;

        done = 1'b1;
        finish_up();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, got no completion, expected completion");
            finish_up();
        end
    end

endmodule